// File: doc/BRIEF.md
# Wide-to-Narrow Burst Read Steering

This block is the read-data path of a 32-bit bus target whose back-end delivers 64-bit quad-words. During a burst read it presents each quad-word as two 32-bit data phases on the address/data lines. After each half is taken by the initiator it pulses an active-low strobe to the back-end, one strobe for the low half and one for the high half. The high-half strobe is the back-end's cue to advance its address counter and present the next quad-word.

A burst may begin on a quad-word boundary, in which case the low half goes out first. It may also begin on the odd double-word, in which case the first phase carries the high half of the current quad-word. Whenever the low half of a fresh quad-word is loaded, its high half is captured at the same time, so the phase that follows never waits on the back-end. The block also drives target-ready and device-select, the output enables of those two lines, and the output enable of the address/data bus. It carries the transaction through its final data phase and into turnaround, and keeps a hit flag raised while the transaction is open.

Top module: `wn_read_steer`

## Requirements
- R1: After a synchronous active-low reset, trdy_n, devsel_n, lo_take_n and hi_take_n are 1 and ad_oe, trdy_oe, devsel_oe and bar_hit are 0.
- R2: A txn_start pulse while idle makes devsel_n 0, bar_hit 1 and ad_oe, trdy_oe and devsel_oe 1 on the next cycle, with trdy_n still 1.
- R3: A phase that needs a fresh quad-word asserts trdy_n (0) only after be_rdy_n has been sampled 0 on two consecutive clock edges. With be_rdy_n held 0 from txn_start onward, trdy_n falls in the third cycle after txn_start is sampled. If be_rdy_n alternates, trdy_n stays 1.
- R4: start_dw is captured with txn_start. 0 starts with the low half (qword_in[31:0]) and 1 starts with the high half (qword_in[63:32]). Successive data phases carry successive double-words: low then high of one quad-word, then low of the next.
- R5: After a low-half transfer that is not the last, the next phase presents the captured high half with trdy_n kept 0, whatever be_rdy_n does.
- R6: In the cycle after a completed transfer (trdy_n and irdy_n both 0 at a clock edge), lo_take_n or hi_take_n pulses 0 for one cycle, according to the half that was taken. The two strobes are never 0 together.
- R7: While trdy_n is 0 and irdy_n is 1, ad_out is held, trdy_n stays 0 and neither strobe pulses.
- R8: A completed transfer with frame_n at 1 is the last one. On the next cycle trdy_n and devsel_n are 1 and still driven (their enables at 1), ad_oe is 0 and bar_hit is 0.
- R9: One cycle after R8, trdy_oe and devsel_oe return to 0 and the block is idle, so a new txn_start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_start | input | 1 | One-cycle pulse: a read transaction to this target begins |
| start_dw | input | 1 | Address bit 2 at start: 1 means the burst starts on the odd double-word |
| frame_n | input | 1 | Initiator frame, active low; 1 marks the final data phase |
| irdy_n | input | 1 | Initiator ready, active low |
| be_rdy_n | input | 1 | Back-end ready, active low |
| qword_in | input | 64 | Quad-word presented by the back-end |
| ad_out | output | 32 | Data driven onto the address/data lines |
| ad_oe | output | 1 | Output enable of the address/data lines |
| trdy_n | output | 1 | Target ready, active low |
| trdy_oe | output | 1 | Output enable of target ready |
| devsel_n | output | 1 | Device select, active low |
| devsel_oe | output | 1 | Output enable of device select |
| lo_take_n | output | 1 | Strobe to back-end: low half taken, active low |
| hi_take_n | output | 1 | Strobe to back-end: high half taken, active low |
| bar_hit | output | 1 | High while the transaction is open |

## Verification
A wrong half-select register shows on the very next data phase as a double-word that is out of sequence, and it also pulses the wrong strobe. The error then carries on, because the back-end advances on the wrong phase and every later word comes from the wrong quad-word. A fault in the ready history shows as trdy_n falling a cycle early or late against back-end ready. A sequencer stuck in turnaround shows within one cycle as an output enable that is still raised. Words are checked at each transfer against a double-word index computed from the start offset, and strobe counts are checked per burst.

// File: rtl/wn_pkg.sv
// Package: shared types for the wide-to-narrow read steering block.
// Assumes nothing beyond IEEE 1800-2017 enums.
package wn_pkg;

    // Sequencer states of one read transaction
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DATA  = 2'd2,
        ST_TURN  = 2'd3
    } wn_state_e;

    // Which 32-bit half of the quad-word the current phase carries
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } wn_half_e;

endpackage

// File: rtl/wn_seq.sv
// Module: wn_seq
// Transaction sequencer. It tracks the open read, the half in flight and the
// back-end ready history. It drives the bus control lines and the take strobes,
// and tells the datapath when to load a fresh quad-word or the captured half.
// Assumes txn_start is a one-cycle pulse and that frame_n rises only together
// with the initiator's final ready phase.
module wn_seq
    import wn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic txn_start,
    input  logic start_dw,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic be_rdy_n,
    output logic trdy_n,
    output logic trdy_oe,
    output logic devsel_n,
    output logic devsel_oe,
    output logic ad_oe,
    output logic bar_hit,
    output logic lo_take_n,
    output logic hi_take_n,
    output logic load_fresh,
    output logic load_hold,
    output logic half_sel
);

    wn_state_e state;
    wn_half_e  half;
    logic      be_seen;
    logic      xfer;

    // A transfer completes when both sides are ready in the data state
    assign xfer = (state == ST_DATA) && !irdy_n;

    // Fresh load: back-end ready on this edge and the one before
    assign load_fresh = (state == ST_FETCH) && !be_rdy_n && be_seen;

    // Captured-half load: a low half was just taken and the burst goes on
    assign load_hold  = xfer && !frame_n && (half == HALF_LO);

    assign half_sel   = half;

    // Sequencer state, control lines and strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            half      <= HALF_LO;
            be_seen   <= 1'b0;
            trdy_n    <= 1'b1;
            trdy_oe   <= 1'b0;
            devsel_n  <= 1'b1;
            devsel_oe <= 1'b0;
            ad_oe     <= 1'b0;
            bar_hit   <= 1'b0;
            lo_take_n <= 1'b1;
            hi_take_n <= 1'b1;
        end else begin
            lo_take_n <= 1'b1;
            hi_take_n <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (txn_start) begin
                        state     <= ST_FETCH;
                        half      <= wn_half_e'(start_dw);
                        be_seen   <= 1'b0;
                        devsel_n  <= 1'b0;
                        devsel_oe <= 1'b1;
                        trdy_n    <= 1'b1;
                        trdy_oe   <= 1'b1;
                        ad_oe     <= 1'b1;
                        bar_hit   <= 1'b1;
                    end
                end
                ST_FETCH: begin
                    be_seen <= !be_rdy_n;
                    if (load_fresh) begin
                        trdy_n <= 1'b0;
                        state  <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (xfer) begin
                        if (half == HALF_LO) begin
                            lo_take_n <= 1'b0;
                        end else begin
                            hi_take_n <= 1'b0;
                        end
                        if (frame_n) begin
                            state    <= ST_TURN;
                            trdy_n   <= 1'b1;
                            devsel_n <= 1'b1;
                            ad_oe    <= 1'b0;
                            bar_hit  <= 1'b0;
                        end else if (half == HALF_LO) begin
                            half <= HALF_HI;
                        end else begin
                            half    <= HALF_LO;
                            state   <= ST_FETCH;
                            trdy_n  <= 1'b1;
                            be_seen <= 1'b0;
                        end
                    end
                end
                default: begin
                    trdy_oe   <= 1'b0;
                    devsel_oe <= 1'b0;
                    state     <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/wn_datapath.sv
// Module: wn_datapath
// Half-word steering. On a fresh load it drives the selected half of the
// quad-word. When that half is the low one it also captures the high half,
// which is then driven on a captured-half load without touching the back-end.
// Assumes load_fresh and load_hold are never high together.
module wn_datapath #(
    parameter int HALF_W = 32,
    localparam int QW_W  = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [QW_W-1:0]   qword_in,
    input  logic              load_fresh,
    input  logic              load_hold,
    input  logic              half_sel,
    output logic [HALF_W-1:0] ad_out
);

    logic [HALF_W-1:0] lo_part;
    logic [HALF_W-1:0] hi_part;
    logic [HALF_W-1:0] hi_hold;

    assign lo_part = qword_in[HALF_W-1:0];
    assign hi_part = qword_in[QW_W-1:HALF_W];

    // Output data register and captured high half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ad_out  <= '0;
            hi_hold <= '0;
        end else if (load_fresh) begin
            if (half_sel) begin
                ad_out <= hi_part;
            end else begin
                ad_out  <= lo_part;
                hi_hold <= hi_part;
            end
        end else if (load_hold) begin
            ad_out <= hi_hold;
        end
    end

endmodule

// File: rtl/wn_read_steer.sv
// Module: wn_read_steer (top)
// Burst read steering from a 64-bit back-end onto a 32-bit target bus.
// It joins the sequencer and the datapath. All outputs are registered on clk.
// Assumes the back-end updates qword_in within one cycle of seeing hi_take_n.
module wn_read_steer #(
    parameter int HALF_W = 32,
    localparam int QW_W  = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic              start_dw,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              be_rdy_n,
    input  logic [QW_W-1:0]   qword_in,
    output logic [HALF_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              trdy_n,
    output logic              trdy_oe,
    output logic              devsel_n,
    output logic              devsel_oe,
    output logic              lo_take_n,
    output logic              hi_take_n,
    output logic              bar_hit
);

    logic load_fresh;
    logic load_hold;
    logic half_sel;

    // Sequencer: control lines, strobes and load requests
    wn_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_start  (txn_start),
        .start_dw   (start_dw),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .be_rdy_n   (be_rdy_n),
        .trdy_n     (trdy_n),
        .trdy_oe    (trdy_oe),
        .devsel_n   (devsel_n),
        .devsel_oe  (devsel_oe),
        .ad_oe      (ad_oe),
        .bar_hit    (bar_hit),
        .lo_take_n  (lo_take_n),
        .hi_take_n  (hi_take_n),
        .load_fresh (load_fresh),
        .load_hold  (load_hold),
        .half_sel   (half_sel)
    );

    // Datapath: half selection and captured high half
    wn_datapath #(.HALF_W(HALF_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .qword_in   (qword_in),
        .load_fresh (load_fresh),
        .load_hold  (load_hold),
        .half_sel   (half_sel),
        .ad_out     (ad_out)
    );

endmodule

// File: rtl/wn_read_steer_chk.sv
// Module: wn_read_steer_chk
// Port-level properties of wn_read_steer, attached by bind below.
// Assumes the synchronous active-low reset is applied at start-up.
module wn_read_steer_chk #(
    parameter int HALF_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irdy_n,
    input logic              frame_n,
    input logic              be_rdy_n,
    input logic [HALF_W-1:0] ad_out,
    input logic              ad_oe,
    input logic              trdy_n,
    input logic              trdy_oe,
    input logic              devsel_n,
    input logic              lo_take_n,
    input logic              hi_take_n,
    input logic              bar_hit
);

    // R6: the two take strobes are never active together
    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lo_take_n && !hi_take_n));

    // R6: a strobe only follows a completed transfer
    a_r6_strobe_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_take_n || !hi_take_n) |-> $past(!trdy_n && !irdy_n));

    // R7: an initiator wait holds the data and target-ready
    a_r7_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && irdy_n) |=> (!trdy_n && $stable(ad_out) && lo_take_n && hi_take_n));

    // R3: target-ready only falls after two back-end ready samples
    a_r3_ready_history: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trdy_n) |-> ($past(!be_rdy_n, 1) && $past(!be_rdy_n, 2)));

    // R8: a final transfer releases the bus and clears the hit
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n && frame_n) |=> (trdy_n && devsel_n && !ad_oe && !bar_hit && trdy_oe));

    // R9: the control-line enables drop one cycle after release
    a_r9_float: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy_oe && !ad_oe && !bar_hit) |=> !trdy_oe);

endmodule

bind wn_read_steer wn_read_steer_chk #(.HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irdy_n    (irdy_n),
    .frame_n   (frame_n),
    .be_rdy_n  (be_rdy_n),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .trdy_n    (trdy_n),
    .trdy_oe   (trdy_oe),
    .devsel_n  (devsel_n),
    .lo_take_n (lo_take_n),
    .hi_take_n (hi_take_n),
    .bar_hit   (bar_hit)
);

// File: tb/wn_read_steer_test.sv
// Bench for wn_read_steer: directed corner cases plus seeded random bursts,
// with a back-end model that advances its quad-word on each high-half strobe.
module wn_read_steer_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        txn_start;
    logic        start_dw;
    logic        frame_n;
    logic        irdy_n;
    logic        be_rdy_n;
    logic [63:0] qword_in;
    logic [31:0] ad_out;
    logic        ad_oe, trdy_n, trdy_oe, devsel_n, devsel_oe;
    logic        lo_take_n, hi_take_n, bar_hit;

    int total = 0;
    int bad   = 0;
    int qidx  = 0;
    int lo_cnt = 0;
    int hi_cnt = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wn_read_steer uut (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .start_dw(start_dw),
        .frame_n(frame_n), .irdy_n(irdy_n), .be_rdy_n(be_rdy_n), .qword_in(qword_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .trdy_n(trdy_n), .trdy_oe(trdy_oe),
        .devsel_n(devsel_n), .devsel_oe(devsel_oe), .lo_take_n(lo_take_n),
        .hi_take_n(hi_take_n), .bar_hit(bar_hit)
    );

    function automatic logic [31:0] lo_of(input int i);
        return 32'hA000_0000 + i;
    endfunction

    function automatic logic [31:0] hi_of(input int i);
        return 32'hB000_0000 + i;
    endfunction

    // Expected double-word k of a burst from quad-word b, start offset s
    function automatic logic [31:0] exp_word(input int b, input bit s, input int k);
        int d;
        d = 2 * b + int'(s) + k;
        return (d % 2 == 1) ? hi_of(d / 2) : lo_of(d / 2);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: wait for the falling edge, then update the back-end model
    task automatic tick();
        @(negedge clk);
        if (!lo_take_n) lo_cnt++;
        if (!hi_take_n) begin
            hi_cnt++;
            qidx++;
        end
        if (!lo_take_n && !hi_take_n)
            check(1'b0, "R6 both strobes", {62'd0, lo_take_n, hi_take_n}, 64'd3);
        qword_in = {hi_of(qidx), lo_of(qidx)};
    endtask

    task automatic set_base(input int b);
        qidx = b;
        qword_in = {hi_of(qidx), lo_of(qidx)};
    endtask

    // Burst of nph phases from quad-word b, start offset s; rnd adds waits
    task automatic run_burst(input int b, input bit s, input int nph, input bit rnd);
        int k;
        int exp_lo;
        int exp_hi;
        int lo0;
        int hi0;
        bit last;
        set_base(b);
        lo0 = lo_cnt;
        hi0 = hi_cnt;
        exp_lo = 0;
        exp_hi = 0;
        for (int j = 0; j < nph; j++) begin
            if (((int'(s) + j) % 2) == 0) exp_lo++; else exp_hi++;
        end
        start_dw = s; txn_start = 1'b1; frame_n = 1'b0; irdy_n = 1'b1;
        be_rdy_n = rnd ? ($urandom % 4 == 0) : 1'b0;
        tick();
        txn_start = 1'b0;
        check(!devsel_n && bar_hit && ad_oe && devsel_oe && trdy_oe && trdy_n,
              "R2 start", {58'd0, devsel_n, bar_hit, ad_oe, devsel_oe, trdy_oe, trdy_n},
              64'b011110 | 64'b1);
        k = 0;
        last = 1'b0;
        while (k < nph) begin
            be_rdy_n = rnd ? ($urandom % 4 == 0) : 1'b0;
            if (!last) begin
                irdy_n = rnd ? ($urandom % 4 == 0) : 1'b0;
                if (k == nph - 1 && !irdy_n) begin
                    frame_n = 1'b1;
                    last = 1'b1;
                end
            end
            if (!trdy_n && !irdy_n) begin
                check(ad_out == exp_word(b, s, k), "R4 data order", {32'd0, ad_out},
                      {32'd0, exp_word(b, s, k)});
                k++;
            end
            tick();
        end
        check(trdy_n && devsel_n && !ad_oe && !bar_hit && trdy_oe && devsel_oe,
              "R8 release", {58'd0, trdy_n, devsel_n, ad_oe, bar_hit, trdy_oe, devsel_oe},
              64'b110011);
        frame_n = 1'b1; irdy_n = 1'b1;
        tick();
        check(!trdy_oe && !devsel_oe, "R9 float", {62'd0, trdy_oe, devsel_oe}, 64'd0);
        check((lo_cnt - lo0) == exp_lo && (hi_cnt - hi0) == exp_hi, "R6 strobe count",
              {32'(lo_cnt - lo0), 32'(hi_cnt - hi0)}, {32'(exp_lo), 32'(exp_hi)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; txn_start = 1'b0; start_dw = 1'b0; frame_n = 1'b1;
        irdy_n = 1'b1; be_rdy_n = 1'b1;
        set_base(0);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        check(trdy_n && devsel_n && lo_take_n && hi_take_n && !ad_oe && !trdy_oe
              && !devsel_oe && !bar_hit, "R1 reset",
              {56'd0, trdy_n, devsel_n, lo_take_n, hi_take_n, ad_oe, trdy_oe, devsel_oe, bar_hit},
              64'hF0);

        // Directed: aligned start, latency, wait, captured half, final release
        set_base(5);
        start_dw = 1'b0; txn_start = 1'b1; frame_n = 1'b0; irdy_n = 1'b1; be_rdy_n = 1'b0;
        tick();
        txn_start = 1'b0;
        check(trdy_n && !devsel_n, "R2 devsel first", {62'd0, trdy_n, devsel_n}, 64'd2);
        tick();
        check(trdy_n, "R3 one sample not enough", {63'd0, trdy_n}, 64'd1);
        tick();
        check(!trdy_n && ad_out == lo_of(5), "R3 R4 first low", {31'd0, trdy_n, ad_out},
              {32'd0, lo_of(5)});
        for (int w = 0; w < 3; w++) begin
            tick();
            check(!trdy_n && ad_out == lo_of(5) && lo_take_n && hi_take_n, "R7 wait hold",
                  {30'd0, trdy_n, lo_take_n, ad_out}, {31'd1, 1'b1, lo_of(5)} & 64'h1_FFFF_FFFF);
        end
        irdy_n = 1'b0; be_rdy_n = 1'b1;
        tick();
        check(!lo_take_n && hi_take_n, "R6 low strobe", {62'd0, lo_take_n, hi_take_n}, 64'd1);
        check(!trdy_n && ad_out == hi_of(5), "R5 captured high", {31'd0, trdy_n, ad_out},
              {32'd0, hi_of(5)});
        frame_n = 1'b1;
        tick();
        check(!hi_take_n && lo_take_n, "R6 high strobe", {62'd0, lo_take_n, hi_take_n}, 64'd2);
        check(trdy_n && devsel_n && !ad_oe && !bar_hit && trdy_oe, "R8 directed release",
              {59'd0, trdy_n, devsel_n, ad_oe, bar_hit, trdy_oe}, 64'b11001);
        irdy_n = 1'b1;
        tick();
        check(!trdy_oe && !devsel_oe && hi_take_n, "R9 directed float",
              {61'd0, trdy_oe, devsel_oe, hi_take_n}, 64'd1);
        check(qidx == 6, "R6 back-end advanced", 64'(qidx), 64'd6);

        // Directed: alternating back-end ready never asserts target-ready
        set_base(9);
        start_dw = 1'b1; txn_start = 1'b1; frame_n = 1'b0; be_rdy_n = 1'b1;
        tick();
        txn_start = 1'b0;
        for (int w = 0; w < 6; w++) begin
            be_rdy_n = ~be_rdy_n;
            tick();
            check(trdy_n, "R3 alternating ready", {63'd0, trdy_n}, 64'd1);
        end
        be_rdy_n = 1'b0;
        tick();
        tick();
        check(!trdy_n && ad_out == hi_of(9), "R4 odd start high first", {31'd0, trdy_n, ad_out},
              {32'd0, hi_of(9)});
        irdy_n = 1'b0; frame_n = 1'b1;
        tick();
        check(!hi_take_n && trdy_n && !bar_hit, "R8 single phase",
              {61'd0, hi_take_n, trdy_n, bar_hit}, 64'd2);
        irdy_n = 1'b1;
        tick();

        // Directed bursts without waits, both offsets
        run_burst(20, 1'b0, 6, 1'b0);
        run_burst(40, 1'b1, 5, 1'b0);

        // Seeded random bursts with initiator and back-end waits
        for (int n = 0; n < 20; n++) begin
            run_burst(100 + 16 * n, 1'($urandom % 2), 1 + int'($urandom % 7), 1'b1);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule